// File: doc/BRIEF.md
# ADC Sample-and-Convert Sequencer

This block is the control sequencer of a successive-approximation converter. A start request comes from one of four sources, chosen by a 2-bit select: a software start strobe or one of three timer compare outputs. The timer outputs are routed inside the chip. The sequencer then opens a sample window. In pulse mode an internal counter sets the window length. In extended mode the window follows the level of the selected hardware trigger. After the window closes, the sequencer runs a fixed 13-tick conversion and a one-tick store phase. In the store phase it latches the converter data into a result register and raises a completion flag.

All sequencing advances on a conversion tick. The tick comes from an integer divider on `clk`. The three hardware trigger lines are each synchronised by two flops in that tick domain before a rising edge is detected. In the analog model, the sampling switch and comparator are replaced by a tick counter, and the converted value is taken from a stub input.

An enable gate controls whether triggers are accepted. With a software trigger, a fresh strobe starts each new conversion. With a hardware trigger in single mode, the enable must be dropped and raised again before the next conversion. In repeat mode, every hardware edge starts a new conversion. Edges that arrive while a conversion is under way are dropped.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After synchronous reset, `busy`, `sampling`, `irq_flag` and `result` are all 0.
- R2: `trig_sel` picks the trigger source: 0 is the `sw_start` strobe, and codes 1, 2 and 3 are `tmr_cmp[0]`, `tmr_cmp[1]` and `tmr_cmp[2]`. Activity on a timer line that is not selected starts nothing.
- R3: In pulse mode (`ext_mode`=0, or any software-started conversion), `sampling` is high for `sht_len`+1 ticks. `busy` is high for `sht_len`+15 ticks: the sample window, 13 conversion ticks and 1 store tick. `sht_len` spans 0..1023, so the window can be up to 1024 ticks.
- R4: One conversion tick occurs every `clk_div`+1 cycles of `clk`. Every duration in R3 and R5 is measured in these ticks.
- R5: In extended mode (`ext_mode`=1, hardware trigger), sampling starts on a rising edge of the selected line and lasts as long as that line stays high. With `clk_div`=0, a line held high for H clocks gives H sampling clocks and H+14 busy clocks.
- R6: `result` takes the value of `conv_data` and `irq_flag` rises at the same clock edge where `busy` falls.
- R7: A one-cycle `rd_result` pulse clears `irq_flag`. If a store happens in the same cycle, the store wins.
- R8: In single mode (`rpt_mode`=0) with a hardware trigger, the next edge after a finished conversion is ignored. A conversion is accepted again once `enc` has gone low and then high.
- R9: In repeat mode (`rpt_mode`=1) with a hardware trigger, each rising edge starts a conversion without toggling `enc`.
- R10: With the software source, each new `sw_start` strobe starts another conversion, even in single mode.
- R11: A trigger edge that arrives while `busy` is high is dropped. It neither extends the current conversion nor starts another one.
- R12: When `enc` is low, no conversion starts. Clearing `enc` during a conversion does not cut it short; the conversion still completes and stores its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; conversion ticks are derived from it |
| rst | input | 1 | Synchronous active-high reset |
| enc | input | 1 | Enable gate for accepting triggers |
| sw_start | input | 1 | Software start strobe |
| trig_sel | input | 2 | Trigger source select |
| tmr_cmp | input | 3 | Timer compare outputs used as hardware triggers |
| ext_mode | input | 1 | 1: trigger level sets the sample window |
| rpt_mode | input | 1 | 1: repeat on the same channel |
| sht_len | input | 10 | Sample window length minus one, in ticks |
| clk_div | input | 3 | Conversion tick divider minus one |
| conv_data | input | 12 | Stub converter output |
| rd_result | input | 1 | Result read strobe, clears the flag |
| result | output | 12 | Stored conversion result |
| irq_flag | output | 1 | Completion flag |
| busy | output | 1 | High from sample start until the result is stored |
| sampling | output | 1 | High during the sample window |

## Verification
Several properties are checked on every clock. A completion flag may only rise together with a falling `busy`. Every conversion phase must last exactly 13 ticks. A conversion may only start while the enable is high. An extended-mode window must stay open while its trigger is high. A read must clear the flag.

Some behaviour can only be shown by the bench's scenarios, because it depends on what did not happen afterwards. These scenarios cover exact window and busy lengths across divider settings, and the rejection of unselected or mid-conversion edges. They also cover the enable-toggle rule in single hardware mode, and the retriggering in repeat and software modes.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SAMPLE,
        ST_CONV,
        ST_STORE
    } seq_state_e;

    localparam int unsigned CONV_TICKS = 13;

    // Trigger event as seen by the sequencer, in the tick domain
    typedef struct packed {
        logic start;   // qualifying start event this tick
        logic level;   // synchronised level of the selected hardware line
        logic is_hw;   // selected source is a timer line
    } trig_info_t;

    function automatic logic src_is_hw(input logic [1:0] sel);
        return sel != 2'd0;
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= div);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_seq_pkg::*;
#(
    parameter int N_HW = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            tick,
    input  logic [1:0]      sel,
    input  logic            sw_start,
    input  logic [N_HW-1:0] hw,
    output trig_info_t      info
);
    logic [N_HW-1:0] s_meta, s_sync, s_prev;
    logic            sw_req;

    // Two-flop synchroniser plus history flop, all in the tick domain
    always_ff @(posedge clk) begin
        if (rst) begin
            s_meta <= '0;
            s_sync <= '0;
            s_prev <= '0;
        end else if (tick) begin
            s_meta <= hw;
            s_sync <= s_meta;
            s_prev <= s_sync;
        end
    end

    // Software strobe held until the next tick consumes it
    always_ff @(posedge clk) begin
        if (rst)           sw_req <= 1'b0;
        else if (sw_start) sw_req <= 1'b1;
        else if (tick)     sw_req <= 1'b0;
    end

    always_comb begin
        info = '0;
        if (!src_is_hw(sel)) begin
            info.start = sw_req;
        end else begin
            for (int i = 0; i < N_HW; i++) begin
                if (int'(sel) == i + 1) begin
                    info.start = s_sync[i] & ~s_prev[i];
                    info.level = s_sync[i];
                    info.is_hw = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int SHT_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             enc,
    input  logic             ext_mode,
    input  logic             rpt_mode,
    input  logic [SHT_W-1:0] sht,
    input  trig_info_t       trig,
    output logic             busy,
    output logic             sampling,
    output logic             store
);
    localparam int CNT_W = (SHT_W > 4) ? SHT_W : 4;

    seq_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic             blk;   // single hardware mode awaits an enable toggle
    logic             ext_win;

    assign ext_win  = ext_mode && trig.is_hw;
    assign busy     = (st == ST_SAMPLE) || (st == ST_CONV) || (st == ST_STORE);
    assign sampling = (st == ST_SAMPLE);
    assign store    = tick && (st == ST_STORE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            cnt <= '0;
            blk <= 1'b0;
        end else begin
            if (!enc) blk <= 1'b0;
            if (tick) begin
                case (st)
                    ST_IDLE: if (enc && !blk) st <= ST_WAIT;
                    ST_WAIT: begin
                        if (!enc) st <= ST_IDLE;
                        else if (trig.start) begin
                            st  <= ST_SAMPLE;
                            cnt <= CNT_W'(sht);
                        end
                    end
                    ST_SAMPLE: begin
                        if (ext_win) begin
                            if (!trig.level) begin
                                st  <= ST_CONV;
                                cnt <= CNT_W'(CONV_TICKS - 1);
                            end
                        end else if (cnt == '0) begin
                            st  <= ST_CONV;
                            cnt <= CNT_W'(CONV_TICKS - 1);
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    ST_CONV: begin
                        if (cnt == '0) st <= ST_STORE;
                        else           cnt <= cnt - 1'b1;
                    end
                    ST_STORE: begin
                        if (!enc) st <= ST_IDLE;
                        else if (!trig.is_hw || rpt_mode) st <= ST_WAIT;
                        else begin
                            st  <= ST_IDLE;
                            blk <= 1'b1;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // Checker: count ticks spent in the conversion phase
    logic [4:0] conv_seen;
    always_ff @(posedge clk) begin
        if (rst || st != ST_CONV) conv_seen <= '0;
        else if (tick)            conv_seen <= conv_seen + 1'b1;
    end

    assert_conv_len_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_STORE && $past(st) == ST_CONV) |-> conv_seen == 5'(CONV_TICKS))
        else $error("conversion phase length wrong");

    assert_start_enc_R12: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(enc))
        else $error("conversion started without enable");

    assert_ext_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SAMPLE && ext_win && trig.level && tick) |=> sampling)
        else $error("extended window closed while trigger high");
endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [RES_W-1:0] din,
    input  logic             rd,
    output logic [RES_W-1:0] result,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            irq    <= 1'b0;
        end else if (wr) begin
            result <= din;
            irq    <= 1'b1;
        end else if (rd) begin
            irq    <= 1'b0;
        end
    end

    assert_irq_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (rd && !wr) |=> !irq)
        else $error("read did not clear flag");
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int SHT_W = 10,
    parameter int DIV_W = 3,
    parameter int N_HW  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enc,
    input  logic             sw_start,
    input  logic [1:0]       trig_sel,
    input  logic [N_HW-1:0]  tmr_cmp,
    input  logic             ext_mode,
    input  logic             rpt_mode,
    input  logic [SHT_W-1:0] sht_len,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [RES_W-1:0] conv_data,
    input  logic             rd_result,
    output logic [RES_W-1:0] result,
    output logic             irq_flag,
    output logic             busy,
    output logic             sampling
);
    logic       tick;
    logic       store;
    trig_info_t trig;

    adc_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst(rst), .div(clk_div), .tick(tick)
    );

    adc_trig_sel #(.N_HW(N_HW)) u_trig (
        .clk(clk), .rst(rst), .tick(tick), .sel(trig_sel),
        .sw_start(sw_start), .hw(tmr_cmp), .info(trig)
    );

    adc_seq_fsm #(.SHT_W(SHT_W)) u_fsm (
        .clk(clk), .rst(rst), .tick(tick), .enc(enc),
        .ext_mode(ext_mode), .rpt_mode(rpt_mode), .sht(sht_len),
        .trig(trig), .busy(busy), .sampling(sampling), .store(store)
    );

    adc_result_reg #(.RES_W(RES_W)) u_res (
        .clk(clk), .rst(rst), .wr(store), .din(conv_data),
        .rd(rd_result), .result(result), .irq(irq_flag)
    );

    assert_flag_with_store_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_flag) |-> $fell(busy))
        else $error("flag rose without busy falling");
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc = 1'b0, sw_start = 1'b0, ext_mode = 1'b0, rpt_mode = 1'b1;
    logic [1:0]  trig_sel = 2'd1;
    logic [2:0]  tmr_cmp = 3'b000;
    logic [9:0]  sht_len = 10'd3;
    logic [2:0]  clk_div = 3'd0;
    logic [11:0] conv_data = 12'h000;
    logic        rd_result = 1'b0;
    logic [11:0] result;
    logic        irq_flag, busy, sampling;

    int n_chk = 0, n_fail = 0;

    adc_seq_ctrl u_adc_seq_ctrl (
        .clk(clk), .rst(rst), .enc(enc), .sw_start(sw_start), .trig_sel(trig_sel),
        .tmr_cmp(tmr_cmp), .ext_mode(ext_mode), .rpt_mode(rpt_mode), .sht_len(sht_len),
        .clk_div(clk_div), .conv_data(conv_data), .rd_result(rd_result),
        .result(result), .irq_flag(irq_flag), .busy(busy), .sampling(sampling)
    );

    always #5 clk = ~clk;

    function automatic int exp_busy_pulse(input int sht, input int div);
        return (sht + 15) * (div + 1);
    endfunction
    function automatic int exp_samp_pulse(input int sht, input int div);
        return (sht + 1) * (div + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fire_hw(input int idx, input int hold);
        tmr_cmp[idx] = 1'b1;
        repeat (hold) @(negedge clk);
        tmr_cmp[idx] = 1'b0;
    endtask

    task automatic fire_sw();
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
    endtask

    task automatic clear_flag(input string req);
        rd_result = 1'b1;
        @(negedge clk);
        rd_result = 1'b0;
        chk(irq_flag == 1'b0, req, irq_flag, 0);
    endtask

    task automatic measure(input int tmo, output int bc, output int sc);
        bc = 0; sc = 0;
        for (int i = 0; i < tmo && !busy; i++) @(negedge clk);
        while (busy) begin
            bc++;
            if (sampling) sc++;
            @(negedge clk);
        end
    endtask

    task automatic check_done(input string req, input int bc, input int sc,
                              input int eb, input int es);
        chk(bc == eb, {req, " busy length"}, bc, eb);
        chk(sc == es, {req, " sample length"}, sc, es);
        chk(irq_flag == 1'b1, "R6 flag at store", irq_flag, 1);
        chk(result == conv_data, "R6 result value", result, conv_data);
    endtask

    task automatic expect_quiet(input int n, input string req);
        int hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (busy) hi++;
        end
        chk(hi == 0, req, hi, 0);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
                $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
                $finish;
            end
        end
    end

    initial begin
        int bc, sc;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        chk(busy == 0 && sampling == 0, "R1 busy/sampling reset", {busy, sampling}, 0);
        chk(irq_flag == 0 && result == 0, "R1 flag/result reset", {irq_flag, result}, 0);
        rst = 1'b0;
        enc = 1'b1;
        repeat (3) @(negedge clk);

        // Shortest and longest pulse windows (R3)
        sht_len = 10'd0; conv_data = 12'h5A5;
        fork fire_hw(0, 2); measure(100, bc, sc); join
        check_done("R3 min", bc, sc, exp_busy_pulse(0, 0), exp_samp_pulse(0, 0));
        clear_flag("R7 read clears");
        sht_len = 10'd1023; conv_data = 12'hA5A;
        fork fire_hw(0, 2); measure(100, bc, sc); join
        check_done("R3 max", bc, sc, exp_busy_pulse(1023, 0), exp_samp_pulse(1023, 0));

        // Random sources, windows and dividers in repeat mode (R2 R3 R4 R10)
        for (int it = 0; it < 10; it++) begin
            int s, d, src;
            s = $urandom_range(50, 0);
            d = $urandom_range(3, 0);
            src = $urandom_range(3, 0);
            clear_flag("R7 read clears");
            sht_len = 10'(s); clk_div = 3'(d); trig_sel = 2'(src);
            conv_data = 12'($urandom);
            repeat (8) @(negedge clk);
            if (src == 0) begin
                fork fire_sw(); measure(200, bc, sc); join
            end else begin
                fork fire_hw(src - 1, 2 * (d + 1)); measure(200, bc, sc); join
            end
            check_done("R4 R2 divided", bc, sc, exp_busy_pulse(s, d), exp_samp_pulse(s, d));
        end

        // Extended mode windows (R5)
        clk_div = 3'd0; trig_sel = 2'd3; ext_mode = 1'b1;
        for (int h = 7; h <= 21; h += 14) begin
            clear_flag("R7 read clears");
            conv_data = 12'(h * 97);
            repeat (4) @(negedge clk);
            fork fire_hw(2, h); measure(100, bc, sc); join
            check_done("R5 ext", bc, sc, h + 14, h);
        end
        ext_mode = 1'b0;

        // Single hardware mode needs enable toggle (R8)
        rpt_mode = 1'b0; trig_sel = 2'd2; sht_len = 10'd5; clk_div = 3'd1;
        clear_flag("R7 read clears");
        fork fire_hw(1, 4); measure(100, bc, sc); join
        check_done("R8 first", bc, sc, exp_busy_pulse(5, 1), exp_samp_pulse(5, 1));
        fire_hw(1, 4);
        expect_quiet(60, "R8 no retrigger without toggle");
        enc = 1'b0; repeat (4) @(negedge clk);
        enc = 1'b1; repeat (4) @(negedge clk);
        fork fire_hw(1, 4); measure(100, bc, sc); join
        check_done("R8 after toggle", bc, sc, exp_busy_pulse(5, 1), exp_samp_pulse(5, 1));

        // Software retrigger in single mode (R10)
        trig_sel = 2'd0; clk_div = 3'd0;
        enc = 1'b0; repeat (3) @(negedge clk);
        enc = 1'b1; repeat (3) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            clear_flag("R7 read clears");
            fork fire_sw(); measure(100, bc, sc); join
            check_done("R10 sw repeat", bc, sc, exp_busy_pulse(5, 0), exp_samp_pulse(5, 0));
        end

        // Unselected lines ignored (R2), selected line accepted
        trig_sel = 2'd2;
        repeat (3) @(negedge clk);
        fire_hw(0, 3); fire_hw(2, 3);
        expect_quiet(30, "R2 unselected line ignored");
        fork fire_hw(1, 3); measure(100, bc, sc); join
        check_done("R2 selected", bc, sc, exp_busy_pulse(5, 0), exp_samp_pulse(5, 0));

        // Repeat mode, edge during conversion dropped (R9 R11)
        rpt_mode = 1'b1; trig_sel = 2'd1; sht_len = 10'd40;
        enc = 1'b0; repeat (3) @(negedge clk);
        enc = 1'b1; repeat (3) @(negedge clk);
        fork
            begin fire_hw(0, 2); repeat (12) @(negedge clk); fire_hw(0, 2); end
            measure(100, bc, sc);
        join
        chk(bc == exp_busy_pulse(40, 0), "R11 busy not extended", bc, exp_busy_pulse(40, 0));
        expect_quiet(30, "R11 dropped edge no new conversion");
        fork fire_hw(0, 2); measure(100, bc, sc); join
        chk(bc == exp_busy_pulse(40, 0), "R9 repeat without toggle", bc, exp_busy_pulse(40, 0));

        // Enable gate (R12)
        enc = 1'b0; repeat (3) @(negedge clk);
        fire_hw(0, 3);
        expect_quiet(30, "R12 no start while disabled");
        enc = 1'b1; repeat (3) @(negedge clk);
        clear_flag("R7 read clears");
        conv_data = 12'h3C3;
        fork
            fire_hw(0, 2);
            begin
                for (int i = 0; i < 100 && !busy; i++) @(negedge clk);
                repeat (3) @(negedge clk);
                enc = 1'b0;
            end
            measure(100, bc, sc);
        join
        check_done("R12 completes after disable", bc, sc,
                   exp_busy_pulse(40, 0), exp_samp_pulse(40, 0));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule